// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the opcode and function fields of a fetched instruction, together with the ALU equality flag, into the full set of datapath control points for a 32-bit single-cycle load/store processor. It decides where the register file writes, whether the ALU's second operand is a register or the extended immediate, how the immediate is extended, which ALU operation runs, whether the writeback value comes from data memory, which storage element is written, and whether the next PC takes the branch target.

The decoder is purely combinational and holds no state. Each output settles in the same cycle that a new instruction is presented. It recognises load word, store word, branch-if-equal, add-immediate and the register-register operations add, sub, and, or and set-less-than. Any other encoding does no harm: the register file and data memory are not written, and the PC advances sequentially. The register file, ALU, extender and memories sit outside the block.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: Opcode 0x00 marks a register-register instruction. Opcodes 0x23, 0x2B, 0x04 and 0x08 mark load word, store word, branch-if-equal and add-immediate.
- R2: With opcode 0x00, the funct codes 0x20, 0x22, 0x24, 0x25 and 0x2A drive `alu_op` to 0 (add), 1 (sub), 2 (and), 3 (or) and 4 (slt). They also set `dst_sel_rd`=1, `src_sel_imm`=0, `load_to_reg`=0, `reg_wr_en`=1 and `mem_wr_en`=0.
- R3: Add-immediate gives `dst_sel_rd`=0, `src_sel_imm`=1, `alu_op`=add, `reg_wr_en`=1, `mem_wr_en`=0 and `load_to_reg`=0.
- R4: Load word gives `load_to_reg`=1, `dst_sel_rd`=0, `src_sel_imm`=1, `alu_op`=add, `reg_wr_en`=1 and `mem_wr_en`=0.
- R5: Store word gives `mem_wr_en`=1, `reg_wr_en`=0, `src_sel_imm`=1, `alu_op`=add and `load_to_reg`=0.
- R6: Branch-if-equal gives `alu_op`=sub, `src_sel_imm`=0, and both write enables 0. It sets `pc_branch`=1 exactly when `alu_eq`=1.
- R7: For every instruction other than branch-if-equal, `pc_branch` is 0 whatever the value of `alu_eq`.
- R8: An unrecognised opcode drives every output to 0: both write enables off, sequential PC, and `alu_op`=add.
- R9: Opcode 0x00 with an unrecognised funct gives `reg_wr_en`=0, `mem_wr_en`=0, `pc_branch`=0 and `alu_op`=add.
- R10: `ext_signed` is 1 for load word, store word, branch-if-equal and add-immediate, and 0 for all other encodings.
- R11: The outputs depend only on the present inputs. Changing the inputs within a cycle changes the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_field | input | 6 | Opcode field of the instruction (bits 31:26) |
| fn_field | input | 6 | Function field of the instruction (bits 5:0) |
| alu_eq | input | 1 | ALU equality flag for the current instruction |
| dst_sel_rd | output | 1 | 1: write to rd, 0: write to rt |
| src_sel_imm | output | 1 | 1: ALU operand B is the extended immediate |
| ext_signed | output | 1 | 1: sign-extend the 16-bit immediate |
| alu_op | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 slt |
| load_to_reg | output | 1 | 1: writeback value comes from data memory |
| reg_wr_en | output | 1 | Register file write enable |
| mem_wr_en | output | 1 | Data memory write enable |
| pc_branch | output | 1 | 1: next PC is PC+4 plus the shifted immediate |

## Verification
The bench uses the default 6-bit opcode and funct widths. With these widths it can sweep every one of the 64 opcodes, each with the flag both low and high. It then sweeps all 64 funct codes under the register-register opcode. This covers every unrecognised encoding that sits next to a legal one, and it checks the flag's effect on each instruction class. A separate check changes the instruction in the middle of a cycle to show that no clock is involved.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;

    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int ALUOP_W = 3;

    localparam logic [OPC_W-1:0] OPC_RTYPE  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOADW  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STOREW = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BREQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_ADDIMM = 6'h08;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [ALUOP_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_REG    = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4,
        CLS_ADDI   = 3'd5
    } instr_cls_e;

    typedef struct packed {
        logic dst_rd;
        logic src_imm;
        logic ext_sgn;
        logic ld_to_reg;
        logic reg_wr;
        logic mem_wr;
    } main_ctl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] op_in,
    output instr_cls_e       cls_out,
    output main_ctl_t        ctl_out
);

    always_comb begin
        cls_out = CLS_NONE;
        unique case (op_in)
            OPC_RTYPE:  cls_out = CLS_REG;
            OPC_LOADW:  cls_out = CLS_LOAD;
            OPC_STOREW: cls_out = CLS_STORE;
            OPC_BREQ:   cls_out = CLS_BRANCH;
            OPC_ADDIMM: cls_out = CLS_ADDI;
            default:    cls_out = CLS_NONE;
        endcase
    end

    always_comb begin
        ctl_out = '0;
        unique case (cls_out)
            CLS_REG: begin
                ctl_out.dst_rd = 1'b1;
                ctl_out.reg_wr = 1'b1;
            end
            CLS_LOAD: begin
                ctl_out.src_imm   = 1'b1;
                ctl_out.ext_sgn   = 1'b1;
                ctl_out.ld_to_reg = 1'b1;
                ctl_out.reg_wr    = 1'b1;
            end
            CLS_STORE: begin
                ctl_out.src_imm = 1'b1;
                ctl_out.ext_sgn = 1'b1;
                ctl_out.mem_wr  = 1'b1;
            end
            CLS_BRANCH: begin
                ctl_out.ext_sgn = 1'b1;
            end
            CLS_ADDI: begin
                ctl_out.src_imm = 1'b1;
                ctl_out.ext_sgn = 1'b1;
                ctl_out.reg_wr  = 1'b1;
            end
            default: ctl_out = '0;
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_ctrl_pkg::*;
(
    input  instr_cls_e      cls_in,
    input  logic [FN_W-1:0] fn_in,
    output alu_op_e         op_out,
    output logic            fn_ok
);

    always_comb begin
        op_out = ALU_ADD;
        fn_ok  = 1'b1;
        unique case (cls_in)
            CLS_REG: begin
                unique case (fn_in)
                    FN_ADD:  op_out = ALU_ADD;
                    FN_SUB:  op_out = ALU_SUB;
                    FN_AND:  op_out = ALU_AND;
                    FN_OR:   op_out = ALU_OR;
                    FN_SLT:  op_out = ALU_SLT;
                    default: begin
                        op_out = ALU_ADD;
                        fn_ok  = 1'b0;
                    end
                endcase
            end
            CLS_BRANCH: op_out = ALU_SUB;
            default:    op_out = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_pc_sel.sv
module sc_pc_sel
    import sc_ctrl_pkg::*;
(
    input  instr_cls_e cls_in,
    input  logic       eq_in,
    output logic       take_out
);

    always_comb begin
        take_out = 1'b0;
        if (cls_in == CLS_BRANCH) take_out = eq_in;
    end

endmodule

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder
    import sc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0]   op_field,
    input  logic [FN_W-1:0]    fn_field,
    input  logic               alu_eq,
    output logic               dst_sel_rd,
    output logic               src_sel_imm,
    output logic               ext_signed,
    output logic [ALUOP_W-1:0] alu_op,
    output logic               load_to_reg,
    output logic               reg_wr_en,
    output logic               mem_wr_en,
    output logic               pc_branch
);

    instr_cls_e cls_w;
    main_ctl_t  ctl_w;
    alu_op_e    aop_w;
    logic       fn_ok_w;

    sc_main_dec u_main (
        .op_in   (op_field),
        .cls_out (cls_w),
        .ctl_out (ctl_w)
    );

    sc_alu_dec u_alu (
        .cls_in (cls_w),
        .fn_in  (fn_field),
        .op_out (aop_w),
        .fn_ok  (fn_ok_w)
    );

    sc_pc_sel u_pc (
        .cls_in   (cls_w),
        .eq_in    (alu_eq),
        .take_out (pc_branch)
    );

    assign dst_sel_rd  = ctl_w.dst_rd;
    assign src_sel_imm = ctl_w.src_imm;
    assign ext_signed  = ctl_w.ext_sgn;
    assign load_to_reg = ctl_w.ld_to_reg;
    assign alu_op      = aop_w;
    assign reg_wr_en   = ctl_w.reg_wr & fn_ok_w;
    assign mem_wr_en   = ctl_w.mem_wr;

endmodule

// File: rtl/sc_ctrl_decoder_chk.sv
module sc_ctrl_decoder_chk
    import sc_ctrl_pkg::*;
(
    input logic [OPC_W-1:0]   op_field,
    input logic [FN_W-1:0]    fn_field,
    input logic               alu_eq,
    input logic               dst_sel_rd,
    input logic               src_sel_imm,
    input logic               load_to_reg,
    input logic               reg_wr_en,
    input logic               mem_wr_en,
    input logic               pc_branch
);

    always_comb begin
        if (!$isunknown({op_field, fn_field, alu_eq})) begin
            // R5
            memwr_only_store_chk: assert (!mem_wr_en || op_field == OPC_STOREW);
            // R6
            branch_needs_eq_chk: assert (!pc_branch || (alu_eq && op_field == OPC_BREQ));
            // R4
            load_implies_rt_write_chk: assert (!load_to_reg || (reg_wr_en && !dst_sel_rd));
            // R2
            rd_only_rtype_chk: assert (!dst_sel_rd || op_field == OPC_RTYPE);
            // R8
            single_writer_chk: assert (!(reg_wr_en && mem_wr_en));
            // R3
            imm_not_with_rd_chk: assert (!(src_sel_imm && dst_sel_rd));
        end
    end

endmodule

bind sc_ctrl_decoder sc_ctrl_decoder_chk u_chk (
    .op_field    (op_field),
    .fn_field    (fn_field),
    .alu_eq      (alu_eq),
    .dst_sel_rd  (dst_sel_rd),
    .src_sel_imm (src_sel_imm),
    .load_to_reg (load_to_reg),
    .reg_wr_en   (reg_wr_en),
    .mem_wr_en   (mem_wr_en),
    .pc_branch   (pc_branch)
);

// File: tb/sc_ctrl_decoder_tb_top.sv
module sc_ctrl_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op_field = '0;
    logic [5:0] fn_field = '0;
    logic       alu_eq = 1'b0;
    logic       dst_sel_rd, src_sel_imm, ext_signed, load_to_reg;
    logic       reg_wr_en, mem_wr_en, pc_branch;
    logic [2:0] alu_op;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    sc_ctrl_decoder dut_i (
        .op_field    (op_field),
        .fn_field    (fn_field),
        .alu_eq      (alu_eq),
        .dst_sel_rd  (dst_sel_rd),
        .src_sel_imm (src_sel_imm),
        .ext_signed  (ext_signed),
        .alu_op      (alu_op),
        .load_to_reg (load_to_reg),
        .reg_wr_en   (reg_wr_en),
        .mem_wr_en   (mem_wr_en),
        .pc_branch   (pc_branch)
    );

    // Behavioural mnemonic lookup (R1, R2)
    function automatic string mnem(input logic [5:0] op, input logic [5:0] fn);
        if (op == 6'd0) begin
            if (fn == 6'd32) return "add";
            if (fn == 6'd34) return "sub";
            if (fn == 6'd36) return "and";
            if (fn == 6'd37) return "or";
            if (fn == 6'd42) return "slt";
            return "badfn";
        end
        if (op == 6'd35) return "lw";
        if (op == 6'd43) return "sw";
        if (op == 6'd4)  return "beq";
        if (op == 6'd8)  return "addi";
        return "none";
    endfunction

    // Expected {dst,src,ext,alu[2:0],ld,rw,mw,br}
    function automatic logic [9:0] expect_of(input string m, input logic eq);
        case (m)
            "add":  return {1'b1,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,1'b0};
            "sub":  return {1'b1,1'b0,1'b0,3'd1,1'b0,1'b1,1'b0,1'b0};
            "and":  return {1'b1,1'b0,1'b0,3'd2,1'b0,1'b1,1'b0,1'b0};
            "or":   return {1'b1,1'b0,1'b0,3'd3,1'b0,1'b1,1'b0,1'b0};
            "slt":  return {1'b1,1'b0,1'b0,3'd4,1'b0,1'b1,1'b0,1'b0};
            "badfn":return {1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0};
            "lw":   return {1'b0,1'b1,1'b1,3'd0,1'b1,1'b1,1'b0,1'b0};
            "sw":   return {1'b0,1'b1,1'b1,3'd0,1'b0,1'b0,1'b1,1'b0};
            "beq":  return {1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0,eq};
            "addi": return {1'b0,1'b1,1'b1,3'd0,1'b0,1'b1,1'b0,1'b0};
            default:return 10'd0;
        endcase
    endfunction

    function automatic string tag_of(input string m);
        case (m)
            "add", "sub", "and", "or", "slt": return "R2";
            "addi":  return "R3";
            "lw":    return "R4";
            "sw":    return "R5";
            "beq":   return "R6";
            "badfn": return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input string why);
        logic [9:0] got, exp;
        string m;
        m   = mnem(op_field, fn_field);
        exp = expect_of(m, alu_eq);
        got = {dst_sel_rd, src_sel_imm, ext_signed, alu_op, load_to_reg,
               reg_wr_en, mem_wr_en, pc_branch};
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            // R7 on a stray branch, R10 on a wrong extender mode
            $display("FAIL %s%s%s op=%h fn=%h eq=%b actual=%b expected=%b (%s)",
                     tag_of(m), (got[0] !== exp[0]) ? "/R7" : "",
                     (got[7] !== exp[7]) ? "/R10" : "",
                     op_field, fn_field, alu_eq, got, exp, why);
        end
    endtask

    task automatic step(input logic [5:0] op, input logic [5:0] fn, input logic eq,
                        input string why);
        @(negedge clk);
        op_field = op;
        fn_field = fn;
        alu_eq   = eq;
        #2;
        compare(why);
    endtask

    initial begin
        #800000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state after bench reset: all-zero word is an unknown funct (R9)
        step(6'd0, 6'd0, 1'b0, "R9 idle word");
        // Named instructions, both flag values (R2..R6, R10)
        step(6'h00, 6'h20, 1'b1, "R2 add");
        step(6'h00, 6'h22, 1'b0, "R2 sub");
        step(6'h00, 6'h24, 1'b1, "R2 and");
        step(6'h00, 6'h25, 1'b0, "R2 or");
        step(6'h00, 6'h2A, 1'b1, "R2 slt");
        step(6'h08, 6'h15, 1'b1, "R3 addi");
        step(6'h23, 6'h3F, 1'b1, "R4 lw");
        step(6'h2B, 6'h20, 1'b1, "R5 sw");
        step(6'h04, 6'h00, 1'b1, "R6 beq taken");
        step(6'h04, 6'h00, 1'b0, "R6 beq not taken");
        // Full opcode sweep: R1, R7, R8, R10
        for (int op = 0; op < 64; op++) begin
            for (int e = 0; e < 2; e++) begin
                step(6'(op), 6'((op * 7 + 3) & 63), e[0], "R1 opcode sweep");
            end
        end
        // Full funct sweep under opcode 0: R2, R9
        for (int fn = 0; fn < 64; fn++) begin
            step(6'h00, 6'(fn), fn[0], "R9 funct sweep");
        end
        // R11: change mid-cycle, no clock edge in between
        @(negedge clk);
        op_field = 6'h23; fn_field = 6'h00; alu_eq = 1'b0;
        #1 compare("R11 first");
        op_field = 6'h2B;
        #1 compare("R11 second");
        op_field = 6'h04; alu_eq = 1'b1;
        #1 compare("R11 third");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule